// File: doc/BRIEF.md
# DMA Channel Burst Address Sequencer

This block steps one DMA channel through a transfer. While the channel is idle, a load strobe captures a source address, a target address, a byte length and a command (source and target increment flags, source and target flow-control flags, a burst-size code, a width code and a byte-alignment enable). A start pulse then checks the command. If the command is valid, the channel presents a series of bursts on a request/acknowledge handshake. Each burst carries a source address, a target address and a byte count.

Before each burst, the channel waits for a request from the side marked as flow-controlled, if there is one. After each acknowledge, every address whose increment flag is set moves forward by that burst's byte count, and the remaining length shrinks by the same amount. When the length reaches zero, the channel drops its run state and pulses a done strobe. A stop pulse lets the burst in flight finish and then parks the channel with its addresses and remaining length kept, so a later start pulse resumes the transfer from where it stopped.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, `bst_req`, `running`, `done` and `cfg_err` are all 0.
- R2: With `ld_byte_align` clear, a memory-side address is driven with bits [2:0] forced to 0. A peripheral-side address is driven with bits [1:0] forced to 0. The peripheral side is the source when `ld_flow_src` is set and the target when `ld_flow_tgt` is set.
- R3: With `ld_byte_align` set, both addresses are driven exactly as held, with no low bits forced.
- R4: The burst-size code gives the full burst length: 01 is 8 bytes, 10 is 16 bytes, 11 is 32 bytes. After each acknowledge, an address with its increment flag set advances by the burst's byte count. An address with its increment flag clear stays the same on every burst.
- R5: `bst_bytes` is the full burst length, or the remaining length when that is smaller. The smaller value is also used as the final address increment.
- R6: With `ld_flow_tgt` set, a burst is not requested until `tgt_dreq` is high. With `ld_flow_src` set, a burst waits for `src_dreq` only. With neither flag set, `bst_req` rises two clock edges after the start pulse is sampled.
- R7: The channel does not start, and `cfg_err` goes to 1, in any of these cases: the burst-size code is 00; both flow flags are set; both flow flags are clear and the width code is nonzero. A later load clears `cfg_err`.
- R8: The acknowledge of the last burst causes `done` to be 1 for exactly one cycle, and `running` to fall in that same cycle.
- R9: A stop pulse during a burst keeps `bst_req` and its address and count values held until `bst_ack`. The channel then goes idle without `done`. A start pulse resumes from the advanced addresses and the remaining length.
- R10: A start pulse with a loaded length of 0 produces a one-cycle `done` pulse and no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture the ld_* values; honoured only while idle |
| ld_src | input | AW | Source start address |
| ld_tgt | input | AW | Target start address |
| ld_len | input | LW | Transfer length in bytes |
| ld_inc_src | input | 1 | Advance the source address after each burst |
| ld_inc_tgt | input | 1 | Advance the target address after each burst |
| ld_flow_src | input | 1 | Source is a peripheral; each burst waits for src_dreq |
| ld_flow_tgt | input | 1 | Target is a peripheral; each burst waits for tgt_dreq |
| ld_bsize | input | 2 | Burst-size code (01=8, 10=16, 11=32 bytes, 00 invalid) |
| ld_width | input | 2 | Peripheral width code; must be 00 for memory-to-memory |
| ld_byte_align | input | 1 | Pass addresses through without low-bit forcing |
| run_set | input | 1 | Start pulse, honoured only while idle |
| run_clr | input | 1 | Stop pulse, takes effect after the current burst |
| src_dreq | input | 1 | Source-side peripheral request |
| tgt_dreq | input | 1 | Target-side peripheral request |
| bst_ack | input | 1 | Burst completion from the bus side |
| bst_req | output | 1 | Burst request, held until bst_ack |
| bst_src | output | AW | Source address of the current burst |
| bst_tgt | output | AW | Target address of the current burst |
| bst_bytes | output | 6 | Byte count of the current burst |
| running | output | 1 | Channel run state |
| done | output | 1 | One-cycle pulse at the end of the transfer |
| cfg_err | output | 1 | Start was refused because of an invalid command |

## Verification
The bench changes inputs on the falling clock edge and reads outputs on a later falling edge.

Without flow control, `bst_req` is first seen two falling edges after the start pulse is driven. With flow control, it is seen one falling edge after the matching request is raised. `bst_src`, `bst_tgt` and `bst_bytes` are checked on the falling edge where `bst_req` is seen. `done` and `running` are checked one falling edge after the acknowledge is driven, and `done` is checked low again on the edge after that. `cfg_err` is checked one falling edge after the start pulse.

Negative checks sample `bst_req` over several edges of waiting to show that no burst leaks out.

// File: rtl/dma_seq_pkg.sv
// Package: shared types and sizes for the DMA burst sequencer.
// Assumes: byte counts never exceed 32, so a 6-bit count is enough.
package dma_seq_pkg;

    localparam int BYTES_W = 6;

    // Command captured at load time
    typedef struct packed {
        logic       inc_src;
        logic       inc_tgt;
        logic       flow_src;
        logic       flow_tgt;
        logic [1:0] bsize;
        logic [1:0] width;
        logic       byte_align;
    } dma_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dma_cfg_check.sv
// Module: validates a captured command before the channel may start.
// Assumes: the command is stable while the start pulse is evaluated.
module dma_cfg_check
    import dma_seq_pkg::*;
(
    input  dma_cmd_t cmd,
    output logic     bad
);

    logic bad_size;
    logic bad_flow;
    logic bad_width;

    // Flag each illegal combination separately, then merge them
    always_comb begin
        bad_size  = (cmd.bsize == 2'b00);
        bad_flow  = cmd.flow_src && cmd.flow_tgt;
        bad_width = !cmd.flow_src && !cmd.flow_tgt && (cmd.width != 2'b00);
        bad       = bad_size || bad_flow || bad_width;
    end

endmodule

// File: rtl/dma_step_calc.sv
// Module: byte count of the next burst, which is the full burst length
// or the remaining length when that is shorter.
// Assumes: LW >= BW, and a reserved size code is rejected before start.
module dma_step_calc #(
    parameter int LW = 16,
    parameter int BW = 6
) (
    input  logic [1:0]    bsize,
    input  logic [LW-1:0] remain,
    output logic [BW-1:0] bytes
);

    logic [BW-1:0] full;

    // Decode the size code into the full burst length
    always_comb begin
        case (bsize)
            2'b01:   full = BW'(8);
            2'b10:   full = BW'(16);
            2'b11:   full = BW'(32);
            default: full = '0;
        endcase
    end

    // Clip to the remaining length for the final burst
    always_comb begin
        if (remain < LW'(full)) bytes = BW'(remain);
        else                    bytes = full;
    end

endmodule

// File: rtl/dma_addr_align.sv
// Module: forces the low address bits to zero when byte alignment is off.
// Memory-side addresses lose 3 bits; peripheral-side addresses lose 2 bits.
// Assumes: AW >= 3.
module dma_addr_align #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] raw,
    input  logic          periph,
    input  logic          byte_align,
    output logic [AW-1:0] aligned
);

    // Pick the mask that applies to this side of the transfer
    always_comb begin
        aligned = raw;
        if (!byte_align) begin
            if (periph) aligned[1:0] = 2'b00;
            else        aligned[2:0] = 3'b000;
        end
    end

endmodule

// File: rtl/dma_burst_seq.sv
// Module: single-channel DMA burst address and length sequencer.
// Holds the loaded addresses, the remaining length and the command. It
// issues bursts on a request/acknowledge handshake and advances its state
// after each acknowledge.
// Assumes: load and run_set are not given in the same cycle; bst_ack only
// while bst_req is high.
module dma_burst_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [AW-1:0]       ld_src,
    input  logic [AW-1:0]       ld_tgt,
    input  logic [LW-1:0]       ld_len,
    input  logic                ld_inc_src,
    input  logic                ld_inc_tgt,
    input  logic                ld_flow_src,
    input  logic                ld_flow_tgt,
    input  logic [1:0]          ld_bsize,
    input  logic [1:0]          ld_width,
    input  logic                ld_byte_align,
    input  logic                run_set,
    input  logic                run_clr,
    input  logic                src_dreq,
    input  logic                tgt_dreq,
    input  logic                bst_ack,
    output logic                bst_req,
    output logic [AW-1:0]       bst_src,
    output logic [AW-1:0]       bst_tgt,
    output logic [BYTES_W-1:0]  bst_bytes,
    output logic                running,
    output logic                done,
    output logic                cfg_err
);

    localparam int BW    = BYTES_W;
    localparam int NSIDE = 2;

    seq_state_e    state;
    dma_cmd_t      cmd_q;
    logic [AW-1:0] src_q;
    logic [AW-1:0] tgt_q;
    logic [LW-1:0] len_q;
    logic          run_q;
    logic          done_q;
    logic          err_q;

    logic          cfg_bad;
    logic [BW-1:0] step;
    logic          dreq_ok;
    logic          last_burst;

    logic [AW-1:0] side_raw [NSIDE];
    logic          side_per [NSIDE];
    logic [AW-1:0] side_out [NSIDE];

    dma_cfg_check u_cfg (
        .cmd (cmd_q),
        .bad (cfg_bad)
    );

    dma_step_calc #(.LW(LW), .BW(BW)) u_step (
        .bsize  (cmd_q.bsize),
        .remain (len_q),
        .bytes  (step)
    );

    // Index 0 is the source side, index 1 the target side
    assign side_raw[0] = src_q;
    assign side_raw[1] = tgt_q;
    assign side_per[0] = cmd_q.flow_src;
    assign side_per[1] = cmd_q.flow_tgt;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_addr_align #(.AW(AW)) u_align (
            .raw        (side_raw[g]),
            .periph     (side_per[g]),
            .byte_align (cmd_q.byte_align),
            .aligned    (side_out[g])
        );
    end

    // Pacing condition: the flow-controlled side must be requesting
    always_comb begin
        if (cmd_q.flow_tgt)      dreq_ok = tgt_dreq;
        else if (cmd_q.flow_src) dreq_ok = src_dreq;
        else                     dreq_ok = 1'b1;
    end

    assign last_burst = (len_q == LW'(step));

    // Sequencer state, run bit, strobes and the address/length registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cmd_q  <= '0;
            src_q  <= '0;
            tgt_q  <= '0;
            len_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (load) begin
                        src_q <= ld_src;
                        tgt_q <= ld_tgt;
                        len_q <= ld_len;
                        cmd_q <= '{inc_src:    ld_inc_src,
                                   inc_tgt:    ld_inc_tgt,
                                   flow_src:   ld_flow_src,
                                   flow_tgt:   ld_flow_tgt,
                                   bsize:      ld_bsize,
                                   width:      ld_width,
                                   byte_align: ld_byte_align};
                        err_q <= 1'b0;
                    end else if (run_set && !run_clr) begin
                        if (cfg_bad) begin
                            err_q <= 1'b1;
                        end else if (len_q == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            run_q <= 1'b1;
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (run_clr) begin
                        run_q <= 1'b0;
                        state <= ST_IDLE;
                    end else if (dreq_ok) begin
                        state <= ST_BURST;
                    end
                end
                ST_BURST: begin
                    if (run_clr) run_q <= 1'b0;
                    if (bst_ack) begin
                        if (cmd_q.inc_src) src_q <= src_q + AW'(step);
                        if (cmd_q.inc_tgt) tgt_q <= tgt_q + AW'(step);
                        len_q <= len_q - LW'(step);
                        if (last_burst) begin
                            done_q <= 1'b1;
                            run_q  <= 1'b0;
                            state  <= ST_IDLE;
                        end else if (run_clr || !run_q) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign bst_req   = (state == ST_BURST);
    assign bst_src   = side_out[0];
    assign bst_tgt   = side_out[1];
    assign bst_bytes = step;
    assign running   = run_q;
    assign done      = done_q;
    assign cfg_err   = err_q;

endmodule

// File: rtl/dma_burst_seq_chk.sv
// Module: protocol and alignment properties of the burst sequencer,
// attached to every instance by the bind below.
// Assumes: the bus side acknowledges only while a burst is requested.
module dma_burst_seq_chk #(
    parameter int AW = 32,
    parameter int BW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bst_req,
    input logic          bst_ack,
    input logic [AW-1:0] bst_src,
    input logic [AW-1:0] bst_tgt,
    input logic [BW-1:0] bst_bytes,
    input logic          running,
    input logic          done,
    input logic          cfg_err,
    input logic          src_dreq,
    input logic          tgt_dreq,
    input logic          flow_src,
    input logic          flow_tgt,
    input logic          byte_align
);

    // R9: a request is held until it is acknowledged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bst_req && !bst_ack |=> bst_req);

    // R9: burst parameters stay put while waiting for the acknowledge
    p_burst_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bst_req && !bst_ack |=> $stable(bst_src) && $stable(bst_tgt) && $stable(bst_bytes));

    // R2: source low bits forced according to its side
    p_src_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bst_req && !byte_align |-> (flow_src ? (bst_src[1:0] == 2'b00) : (bst_src[2:0] == 3'b000)));

    // R2: target low bits forced according to its side
    p_tgt_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bst_req && !byte_align |-> (flow_tgt ? (bst_tgt[1:0] == 2'b00) : (bst_tgt[2:0] == 3'b000)));

    // R5: every burst moves between 1 and 32 bytes
    p_bytes_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bst_req |-> (bst_bytes != '0) && (bst_bytes <= BW'(32)));

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: at done the channel is neither running nor requesting
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running && !bst_req);

    // R7: a refused command never leaves the channel running
    p_err_nostart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !running && !bst_req);

    // R6: a target-paced burst starts only after the target request was seen
    p_flow_tgt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bst_req) && flow_tgt |-> $past(tgt_dreq));

    // R6: a source-paced burst starts only after the source request was seen
    p_flow_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bst_req) && flow_src |-> $past(src_dreq));

endmodule

bind dma_burst_seq dma_burst_seq_chk #(.AW(AW), .BW(BYTES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bst_req    (bst_req),
    .bst_ack    (bst_ack),
    .bst_src    (bst_src),
    .bst_tgt    (bst_tgt),
    .bst_bytes  (bst_bytes),
    .running    (running),
    .done       (done),
    .cfg_err    (cfg_err),
    .src_dreq   (src_dreq),
    .tgt_dreq   (tgt_dreq),
    .flow_src   (cmd_q.flow_src),
    .flow_tgt   (cmd_q.flow_tgt),
    .byte_align (cmd_q.byte_align)
);

// File: tb/dma_burst_seq_bench.sv
// Bench: a vector table of transfers walked by one loop, then directed
// tests for reset, pacing, refused commands, stop/resume and zero length.
module dma_burst_seq_bench;

    localparam int AW = 32;
    localparam int LW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [31:0] ld_src = '0;
    logic [31:0] ld_tgt = '0;
    logic [15:0] ld_len = '0;
    logic        ld_inc_src = 1'b0, ld_inc_tgt = 1'b0;
    logic        ld_flow_src = 1'b0, ld_flow_tgt = 1'b0;
    logic [1:0]  ld_bsize = 2'b01, ld_width = 2'b00;
    logic        ld_byte_align = 1'b0;
    logic        run_set = 1'b0, run_clr = 1'b0;
    logic        src_dreq = 1'b0, tgt_dreq = 1'b0, bst_ack = 1'b0;
    logic        bst_req, running, done, cfg_err;
    logic [31:0] bst_src, bst_tgt;
    logic [5:0]  bst_bytes;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    dma_burst_seq #(.AW(AW), .LW(LW)) u_dma_burst_seq (
        .clk(clk), .rst_n(rst_n), .load(load),
        .ld_src(ld_src), .ld_tgt(ld_tgt), .ld_len(ld_len),
        .ld_inc_src(ld_inc_src), .ld_inc_tgt(ld_inc_tgt),
        .ld_flow_src(ld_flow_src), .ld_flow_tgt(ld_flow_tgt),
        .ld_bsize(ld_bsize), .ld_width(ld_width), .ld_byte_align(ld_byte_align),
        .run_set(run_set), .run_clr(run_clr),
        .src_dreq(src_dreq), .tgt_dreq(tgt_dreq), .bst_ack(bst_ack),
        .bst_req(bst_req), .bst_src(bst_src), .bst_tgt(bst_tgt),
        .bst_bytes(bst_bytes), .running(running), .done(done), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] tgt;
        logic [15:0] len;
        logic        inc_s;
        logic        inc_t;
        logic        fl_s;
        logic        fl_t;
        logic [1:0]  bsize;
        logic        al;
        logic [7:0]  nb;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1000, 32'h0000_2000, 16'd64, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 8'd2},
        '{32'h0000_3005, 32'h0000_4006, 16'd20, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 8'd3},
        '{32'h0000_5003, 32'h0000_6001, 16'd40, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b1, 8'd3},
        '{32'h0000_7000, 32'h0000_8000, 16'd5,  1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 8'd1},
        '{32'h0000_9004, 32'h0000_A00C, 16'd16, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 8'd2},
        '{32'h0000_0011, 32'h0000_0023, 16'd33, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 8'd5}
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input bit per, input bit al);
        if (al)  return a;
        if (per) return {a[31:2], 2'b00};
        return {a[31:3], 3'b000};
    endfunction

    task automatic do_load(input logic [31:0] s, input logic [31:0] t, input logic [15:0] len,
                           input bit is, input bit it, input bit fs, input bit ft,
                           input logic [1:0] bs, input logic [1:0] w, input bit al);
        ld_src = s; ld_tgt = t; ld_len = len;
        ld_inc_src = is; ld_inc_tgt = it; ld_flow_src = fs; ld_flow_tgt = ft;
        ld_bsize = bs; ld_width = w; ld_byte_align = al;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic pulse_run;
        run_set = 1'b1;
        @(negedge clk);
        run_set = 1'b0;
    endtask

    task automatic wait_req(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            if (bst_req) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // Serve every burst until the length is used up, checking each one
    task automatic serve(input string atag, input logic [31:0] s0, input logic [31:0] t0,
                         input int len, input bit is, input bit it, input bit ps, input bit pt,
                         input bit al, input logic [1:0] bs, output int nb);
        logic [31:0] rs = s0;
        logic [31:0] rt = t0;
        int rem = len;
        int full = 4 << bs;
        bit seen;
        nb = 0;
        while (rem > 0) begin
            int b = (rem < full) ? rem : full;
            wait_req(20, seen);
            chk("R6", "burst requested", 32'(seen), 32'd1);
            if (!seen) return;
            chk(atag, "source address", bst_src, exp_addr(rs, ps, al));
            chk(atag, "target address", bst_tgt, exp_addr(rt, pt, al));
            chk("R5", "burst bytes", 32'(bst_bytes), 32'(b));
            bst_ack = 1'b1;
            @(negedge clk);
            bst_ack = 1'b0;
            if (is) rs = rs + 32'(b);
            if (it) rt = rt + 32'(b);
            rem = rem - b;
            nb++;
            if (rem == 0) begin
                chk("R8", "done after last ack", 32'(done), 32'd1);
                chk("R8", "running after last ack", 32'(running), 32'd0);
                @(negedge clk);
                chk("R8", "done one cycle", 32'(done), 32'd0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int nb;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "bst_req", 32'(bst_req), 32'd0);
        chk("R1", "running", 32'(running), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "cfg_err", 32'(cfg_err), 32'd0);

        // Vector table, requests always present (R2 R3 R4 R5)
        src_dreq = 1'b1; tgt_dreq = 1'b1;
        for (int v = 0; v < NV; v++) begin
            do_load(VEC[v].src, VEC[v].tgt, VEC[v].len, VEC[v].inc_s, VEC[v].inc_t,
                    VEC[v].fl_s, VEC[v].fl_t, VEC[v].bsize, 2'b00, VEC[v].al);
            pulse_run;
            serve(VEC[v].al ? "R3" : (v == 4 ? "R4" : "R2"), VEC[v].src, VEC[v].tgt,
                  int'(VEC[v].len), VEC[v].inc_s, VEC[v].inc_t, VEC[v].fl_s, VEC[v].fl_t,
                  VEC[v].al, VEC[v].bsize, nb);
            chk("R4", "burst count", 32'(nb), 32'(VEC[v].nb));
        end

        // R6 latency without pacing: request two edges after the start pulse
        do_load(32'h100, 32'h200, 16'd8, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0);
        run_set = 1'b1;
        @(negedge clk);
        run_set = 1'b0;
        chk("R6", "no request one edge after start", 32'(bst_req), 32'd0);
        @(negedge clk);
        chk("R6", "request two edges after start", 32'(bst_req), 32'd1);
        serve("R2", 32'h100, 32'h200, 8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, nb);

        // R6 target pacing; a wrong-side request has no effect
        src_dreq = 1'b0; tgt_dreq = 1'b0;
        do_load(32'h300, 32'h404, 16'd8, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 2'b10, 1'b0);
        pulse_run;
        repeat (4) @(negedge clk);
        chk("R6", "held without target request", 32'(bst_req), 32'd0);
        src_dreq = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6", "source request ignored when target paced", 32'(bst_req), 32'd0);
        tgt_dreq = 1'b1;
        @(negedge clk);
        chk("R6", "request after target request", 32'(bst_req), 32'd1);
        serve("R2", 32'h300, 32'h404, 8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, nb);

        // R6 source pacing
        src_dreq = 1'b0; tgt_dreq = 1'b1;
        do_load(32'h504, 32'h600, 16'd8, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 2'b00, 1'b0);
        pulse_run;
        repeat (4) @(negedge clk);
        chk("R6", "held without source request", 32'(bst_req), 32'd0);
        src_dreq = 1'b1;
        @(negedge clk);
        chk("R6", "request after source request", 32'(bst_req), 32'd1);
        serve("R2", 32'h504, 32'h600, 8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, nb);

        // R7 refused commands
        do_load(32'h0, 32'h0, 16'd8, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0);
        pulse_run;
        chk("R7", "size 00 flagged", 32'(cfg_err), 32'd1);
        chk("R7", "size 00 not running", 32'(running), 32'd0);
        repeat (3) @(negedge clk);
        chk("R7", "size 00 no burst", 32'(bst_req), 32'd0);
        do_load(32'h0, 32'h0, 16'd8, 1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0);
        chk("R7", "load clears error", 32'(cfg_err), 32'd0);
        pulse_run;
        chk("R7", "both flows flagged", 32'(cfg_err), 32'd1);
        do_load(32'h0, 32'h0, 16'd8, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 2'b01, 1'b0);
        pulse_run;
        chk("R7", "memory width flagged", 32'(cfg_err), 32'd1);
        repeat (3) @(negedge clk);
        chk("R7", "memory width no burst", 32'(bst_req), 32'd0);

        // R9 stop during a burst, then resume
        do_load(32'h1000, 32'h2000, 16'd24, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0);
        pulse_run;
        wait_req(10, seen);
        chk("R9", "first burst present", 32'(seen), 32'd1);
        run_clr = 1'b1;
        @(negedge clk);
        run_clr = 1'b0;
        chk("R9", "request held after stop", 32'(bst_req), 32'd1);
        chk("R9", "address held after stop", bst_src, 32'h1000);
        bst_ack = 1'b1;
        @(negedge clk);
        bst_ack = 1'b0;
        chk("R9", "running cleared", 32'(running), 32'd0);
        chk("R9", "no done on stop", 32'(done), 32'd0);
        repeat (4) @(negedge clk);
        chk("R9", "no burst while stopped", 32'(bst_req), 32'd0);
        pulse_run;
        serve("R9", 32'h1008, 32'h2008, 16, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, nb);
        chk("R9", "bursts after resume", 32'(nb), 32'd2);

        // R10 zero length
        do_load(32'h40, 32'h80, 16'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0);
        pulse_run;
        chk("R10", "done on zero length", 32'(done), 32'd1);
        chk("R10", "no burst on zero length", 32'(bst_req), 32'd0);
        @(negedge clk);
        chk("R10", "done single cycle", 32'(done), 32'd0);
        chk("R10", "still no burst", 32'(bst_req), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule